// File: doc/BRIEF.md
# FPU Error Signaling Controller

This block chooses the path by which an unmasked floating-point exception, once pending, is made known to the rest of the system. It has two paths. In native handling the block keeps the error inside the core. When the next floating-point instruction tries to issue, the block holds it back and raises a one-cycle trap request that carries exception vector 16. In legacy compatibility handling the block instead pulls an active-low error pin low. That pin is meant to feed an input of an external programmable interrupt controller.

In compatibility handling an active-low ignore input comes from outside. It lets an exception handler keep issuing floating-point instructions before the error is cleared, and those instructions never report the error a second time. The ignore input is asynchronous to the core clock, so it passes through a synchronizer first. The mode bit is sampled only at an instruction boundary that has no error outstanding, so a pending error never moves from one reporting path to the other.

Top module: `fpu_err_signal`

## Requirements
- R1: While reset is asserted and right after it is released, err_n_o is 1, trap_o is 0, trap_vec_o is 0, no error is pending, and compatibility handling (mode 0) is in effect.
- R2: In compatibility handling, a 1 on err_pend_i drives err_n_o to 0 from the next clock edge onward. err_n_o stays 0 until a clear takes effect, including when err_pend_i returns to 0.
- R3: A 1 on clr_err_i drops the pending state, so err_n_o is 1 after the next edge. When err_pend_i is also 1 in that cycle, the clear wins. If err_pend_i is still 1 in the following cycle, the error is captured at the edge after that.
- R4: In compatibility handling, with an error pending and the ignore function inactive, an issue request gives stall_o=1 and issue_ok_o=0. This lasts until the error is cleared or the ignore function becomes active.
- R5: In compatibility handling, with the ignore function active (ign_n_i=0 after synchronization), issue_ok_o follows issue_req_i even though an error is pending. During that time err_n_o stays 0 without ever going high, and trap_o stays 0.
- R6: ign_n_i takes effect only after two rising clock edges, because it passes through a two-stage synchronizer.
- R7: In native handling (mode 1), err_n_o stays 1 at all times. An issue request made while an error is pending is blocked, giving stall_o=1 and issue_ok_o=0.
- R8: In native handling, the first blocked issue attempt makes trap_o 1 for exactly one cycle, in the cycle after the attempt, with trap_vec_o=16 (trap_vec_o is 0 otherwise). No further trap is raised until the error has been cleared.
- R9: In native handling, the ignore input has no effect on stalling.
- R10: issue_mode_i is adopted only in a cycle where an issue is granted and no error is pending. At all other times the mode in effect is kept.
- R11: With no error pending, issue_ok_o equals issue_req_i and stall_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| err_pend_i | input | 1 | Registered flag: an unmasked exception has been recorded |
| clr_err_i | input | 1 | Strobe that clears the pending error |
| issue_req_i | input | 1 | A floating-point instruction asks to issue |
| issue_mode_i | input | 1 | Mode request: 1 native handling, 0 compatibility handling |
| ign_n_i | input | 1 | Asynchronous active-low ignore-error input |
| trap_o | output | 1 | One-cycle internal trap request |
| trap_vec_o | output | 8 | Exception vector, valid with trap_o |
| err_n_o | output | 1 | Active-low external error pin |
| issue_ok_o | output | 1 | Issue granted this cycle |
| stall_o | output | 1 | Issue request held off this cycle |

## Verification
The assertions assume that err_pend_i and clr_err_i are synchronous to clk. They also assume that the only way the effective mode changes is through a granted issue with nothing pending, which is why a rising err_n_o can always be traced back to a clear. The stimulus changes every input shortly after a clock edge, so the synchronizer always sees a clean level. It changes the mode only while nothing is pending, except in the one case that checks a mode request is refused during a pending error. Before each pattern the stimulus clears any pending error, so the trap state starts fresh for each combination in the sweep.

// File: rtl/fes_pkg.sv
package fes_pkg;

    // Registered state of the error signaling controller
    typedef struct packed {
        logic pend;     // an error is outstanding
        logic trapped;  // the native trap was already raised for it
        logic trap;     // trap request output register
        logic native;   // effective mode: 1 native, 0 compatibility
    } fes_state_t;

endpackage

// File: rtl/fes_sync.sv
module fes_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] sh_d;
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = d_i;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/fes_core.sv
module fes_core
    import fes_pkg::*;
#(
    parameter logic RST_NATIVE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic err_pend_i,
    input  logic clr_i,
    input  logic req_i,
    input  logic mode_i,
    input  logic ign_i,
    output logic err_n_o,
    output logic trap_o,
    output logic grant_o,
    output logic stall_o
);

    fes_state_t st_d;
    fes_state_t st_q;
    logic       blocked;
    logic       fire;

    always_comb begin
        // compatibility path blocks only when the ignore function is off
        blocked = st_q.pend & (st_q.native | ~ign_i);
        grant_o = req_i & ~blocked;
        stall_o = req_i & blocked;
        fire    = st_q.native & st_q.pend & req_i & ~st_q.trapped;

        st_d         = st_q;
        st_d.pend    = clr_i ? 1'b0 : (st_q.pend | err_pend_i);
        st_d.trapped = clr_i ? 1'b0 : (st_q.trapped | fire);
        st_d.trap    = fire;
        if (grant_o && !st_q.pend) st_d.native = mode_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend    <= 1'b0;
            st_q.trapped <= 1'b0;
            st_q.trap    <= 1'b0;
            st_q.native  <= RST_NATIVE;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_n_o = ~(st_q.pend & ~st_q.native);
    assign trap_o  = st_q.trap;

    // R3
    clr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> err_n_o);

    // R8
    trap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> !trap_o);

    // R8
    trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> $past(stall_o));

    // R5
    pin_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_n_o) |-> $past(clr_i));

    // R10
    mode_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.native) |-> ($past(grant_o) && !$past(st_q.pend)));

    // R4
    grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && stall_o));

endmodule

// File: rtl/fpu_err_signal.sv
module fpu_err_signal #(
    parameter int   SYNC_STAGES = 2,
    parameter int   VEC_W       = 8,
    parameter int   TRAP_VEC    = 16,
    parameter logic RST_NATIVE  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_pend_i,
    input  logic             clr_err_i,
    input  logic             issue_req_i,
    input  logic             issue_mode_i,
    input  logic             ign_n_i,
    output logic             trap_o,
    output logic [VEC_W-1:0] trap_vec_o,
    output logic             err_n_o,
    output logic             issue_ok_o,
    output logic             stall_o
);

    localparam logic [VEC_W-1:0] VEC = VEC_W'(TRAP_VEC);

    logic ign_n_s;
    logic ign_act;

    fes_sync #(
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) i_ign_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (ign_n_i),
        .q_o  (ign_n_s)
    );

    assign ign_act = ~ign_n_s;

    fes_core #(
        .RST_NATIVE(RST_NATIVE)
    ) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_pend_i(err_pend_i),
        .clr_i     (clr_err_i),
        .req_i     (issue_req_i),
        .mode_i    (issue_mode_i),
        .ign_i     (ign_act),
        .err_n_o   (err_n_o),
        .trap_o    (trap_o),
        .grant_o   (issue_ok_o),
        .stall_o   (stall_o)
    );

    assign trap_vec_o = trap_o ? VEC : '0;

endmodule

// File: tb/test_fpu_err_signal.sv
`timescale 1ns/1ps
module test_fpu_err_signal;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       err_pend_i, clr_err_i, issue_req_i, issue_mode_i, ign_n_i;
    logic       trap_o, err_n_o, issue_ok_o, stall_o;
    logic [7:0] trap_vec_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    fpu_err_signal i_fpu_err_signal (
        .clk         (clk),
        .rst_n       (rst_n),
        .err_pend_i  (err_pend_i),
        .clr_err_i   (clr_err_i),
        .issue_req_i (issue_req_i),
        .issue_mode_i(issue_mode_i),
        .ign_n_i     (ign_n_i),
        .trap_o      (trap_o),
        .trap_vec_o  (trap_vec_o),
        .err_n_o     (err_n_o),
        .issue_ok_o  (issue_ok_o),
        .stall_o     (stall_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic raise_err();
        err_pend_i = 1'b1;
        step();
        err_pend_i = 1'b0;
    endtask

    task automatic clear_err();
        clr_err_i = 1'b1;
        step();
        clr_err_i = 1'b0;
    endtask

    task automatic set_mode(input logic m);
        issue_mode_i = m;
        issue_req_i  = 1'b1;
        step();
        issue_req_i  = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; err_pend_i = 0; clr_err_i = 0; issue_req_i = 0;
        issue_mode_i = 0; ign_n_i = 1'b1;
        repeat (3) step();
        chk("R1 err_n in reset", err_n_o, 1);
        chk("R1 trap in reset", trap_o, 0);
        rst_n = 1'b1;
        step();
        chk("R1 err_n after reset", err_n_o, 1);
        chk("R1 trap_vec after reset", trap_vec_o, 0);

        // R11: nothing pending
        issue_req_i = 1; #1;
        chk("R11 grant idle", issue_ok_o, 1);
        chk("R11 stall idle", stall_o, 0);
        step(); issue_req_i = 0;

        // R2: capture in compatibility mode
        err_pend_i = 1; #1;
        chk("R2 pin before edge", err_n_o, 1);
        step(); err_pend_i = 0;
        chk("R2 pin after edge", err_n_o, 0);
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R2 pin held", err_n_o, 0);
        end

        // R4: stall without ignore
        issue_req_i = 1; #1;
        chk("R4 stall", stall_o, 1);
        chk("R4 grant", issue_ok_o, 0);
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R4 stall held", stall_o, 1);
            chk("R4 no trap", trap_o, 0);
        end

        // R6: ignore takes two edges
        ign_n_i = 0; #1;
        chk("R6 stall before edges", stall_o, 1);
        step();
        chk("R6 stall after one edge", stall_o, 1);
        step();
        chk("R6 grant after two edges", issue_ok_o, 1);

        // R5 / R10: issue past the error, mode request refused
        issue_mode_i = 1;
        for (int i = 0; i < 4; i++) begin
            err_pend_i = (i == 1);
            step();
            chk("R5 pin stays low", err_n_o, 0);
            chk("R5 grant", issue_ok_o, 1);
            chk("R5 no trap", trap_o, 0);
        end
        err_pend_i = 0; issue_mode_i = 0;

        // R4: releasing ignore restores the stall
        ign_n_i = 1; step(); step();
        chk("R4 stall after ignore release", stall_o, 1);
        chk("R10 still compatibility", err_n_o, 0);

        // R3: clear
        clear_err();
        chk("R3 pin released", err_n_o, 1);
        chk("R4 grant after clear", issue_ok_o, 1);
        issue_req_i = 0;

        // R3: clear priority
        err_pend_i = 1; clr_err_i = 1;
        step(); clr_err_i = 0;
        chk("R3 clear wins", err_n_o, 1);
        step(); err_pend_i = 0;
        chk("R3 captured next", err_n_o, 0);
        clear_err();
        chk("R3 cleared", err_n_o, 1);

        // R10: mode request without issue has no effect
        issue_mode_i = 1;
        repeat (3) step();
        raise_err();
        chk("R10 no boundary no switch", err_n_o, 0);
        clear_err();

        // switch to native at a boundary
        set_mode(1);

        // R7 / R8
        raise_err();
        chk("R7 pin high native", err_n_o, 1);
        issue_req_i = 1; #1;
        chk("R7 stall native", stall_o, 1);
        chk("R7 grant native", issue_ok_o, 0);
        chk("R8 no trap yet", trap_o, 0);
        step();
        chk("R8 trap pulse", trap_o, 1);
        chk("R8 vector", trap_vec_o, 16);
        step();
        chk("R8 trap ends", trap_o, 0);
        chk("R8 vector clears", trap_vec_o, 0);
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R8 no retrap", trap_o, 0);
            chk("R7 stall held", stall_o, 1);
        end

        // R9: ignore ignored in native
        ign_n_i = 0;
        repeat (3) step();
        chk("R9 stall native ignore", stall_o, 1);
        chk("R9 grant native ignore", issue_ok_o, 0);
        chk("R7 pin native ignore", err_n_o, 1);
        ign_n_i = 1; step(); step();

        clear_err();
        chk("R7 grant after clear", issue_ok_o, 1);
        issue_req_i = 0;
        raise_err();
        issue_req_i = 1;
        step();
        chk("R8 trap rearmed", trap_o, 1);
        issue_req_i = 0;
        clear_err();

        // Exhaustive sweep over mode, pending, ignore, request
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 2; p++) begin
                for (int ig = 0; ig < 2; ig++) begin
                    for (int rq = 0; rq < 2; rq++) begin
                        int blk;
                        set_mode(m[0]);
                        ign_n_i = ~ig[0];
                        step(); step();
                        if (p == 1) raise_err();
                        issue_req_i = rq[0]; #1;
                        blk = p & (m | (1 - ig));
                        chk("R4 R5 R7 R9 R11 sweep grant", issue_ok_o, rq & (1 - blk));
                        chk("R4 R5 R7 R9 R11 sweep stall", stall_o, rq & blk);
                        chk("R2 R7 sweep pin", err_n_o, 1 - (p & (1 - m)));
                        issue_req_i = 0;
                        clear_err();
                        ign_n_i = 1; step(); step();
                    end
                end
            end
        end

        finish_run();
    end

endmodule